// File: doc/BRIEF.md
# Network Status LED Controller

This block drives the three active-low status lamps of a twisted-pair network port: a link lamp, an activity lamp and a polarity-fault lamp. It is fed from the port's link monitor, from per-frame transmit, receive and collision event pulses, from a polarity detector and from a free-running one-millisecond tick. All timing inside the block is counted in those ticks, so the lamp timing does not depend on the core clock frequency.

The link lamp shows whether the twisted-pair link is usable. It is held on while link checking is switched off, and it is forced off whenever the alternate port carries the traffic. Once it goes off it stays off for a guaranteed minimum number of ticks, so a short glitch is still visible to a person. The activity lamp turns each burst of events into a fixed-length flash followed by a fixed dark gap. This bounds the flash rate, and busier traffic makes the lamp blink faster up to that bound. The polarity lamp reports reversed receive wires. It stays lit while the reversal is flagged, even when the receiver has already corrected for it.

Top module: `net_led_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all three LED outputs are 1 (dark) after that edge.
- R2: With `link_chk_en`=1, `alt_port_act`=0 and `link_ok`=1, and no off-hold pending, `led_link_n` is 0 (lit) from the second clock edge onward.
- R3: With `link_chk_en`=0 and `alt_port_act`=0, the link lamp request is on whatever `link_ok` is, so `led_link_n` is 0 once no off-hold is pending.
- R4: A clock edge that samples `alt_port_act`=1, or `link_chk_en`=1 with `link_ok`=0, sets `led_link_n` to 1 at that edge.
- R5: After the last edge with a dark condition from R4, `led_link_n` stays 1 until LINK_OFF_MS (default 100) `ms_tick` pulses have been sampled at later edges. It turns 0 one edge after the last of those ticks. A new dark condition inside the window starts the count again.
- R6: An edge that samples any of `ev_tx`, `ev_rx`, `ev_col` high while the activity lamp is idle lights `led_act_n` (0) at that edge. The lamp stays lit until ACT_ON_MS (default 50) ticks have been sampled at later edges, and it goes dark at the edge of the last of those ticks.
- R7: Events sampled while the activity lamp is lit neither lengthen nor restart the flash.
- R8: After a flash, `led_act_n` stays 1 for ACT_GAP_MS (default 50) ticks and ignores events during that gap. An event sampled at any later edge starts a new flash.
- R9: `led_pol_n` equals the inverse of `pol_rev` as sampled at the previous edge, regardless of link, port or activity state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| link_ok | input | 1 | Link monitor reports a good twisted-pair link |
| link_chk_en | input | 1 | Link integrity checking enabled |
| alt_port_act | input | 1 | Alternate (non twisted-pair) port is carrying traffic |
| ev_tx | input | 1 | One-cycle pulse per transmit event |
| ev_rx | input | 1 | One-cycle pulse per receive event |
| ev_col | input | 1 | One-cycle pulse per collision event |
| pol_rev | input | 1 | Receive pair polarity reversed flag |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| led_link_n | output | 1 | Link lamp, 0 = lit |
| led_act_n | output | 1 | Activity lamp, 0 = lit |
| led_pol_n | output | 1 | Polarity fault lamp, 0 = lit |

## Verification
The bench targets the exact tick on which each window closes. It checks that the link lamp is still dark on the cycle its off-hold reaches zero and lights on the next cycle. A design with an off-by-one count would light one tick early and break the minimum off time. A second link drop in the middle of the hold must restart the count, and a design that kept the old count would light too soon. An event in the middle of a flash must not stretch it, and an event inside the dark gap must not relight the lamp. A design that retriggered on every event would stay lit under heavy traffic instead of blinking. The bench also checks that switching off link checking keeps the lamp lit with `link_ok` low, and that the polarity lamp ignores every link condition.

// File: rtl/net_led_pkg.sv
// Package: net_led_pkg
// Shared types for the network status LED controller.
// Assumes nothing beyond being compiled ahead of its users.
package net_led_pkg;

    // Phases of the activity lamp: waiting, flashing, enforced dark gap.
    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_ON   = 2'd1,
        ACT_GAP  = 2'd2
    } act_phase_e;

endpackage

// File: rtl/led_link_hold.sv
// Module: led_link_hold
// Drives the link lamp. The lamp request is on when the alternate port is
// idle and either checking is off or the link is good. Each cycle that the
// request is off reloads a hold counter, and the lamp lights only once the
// hold has been drained by OFF_MS millisecond ticks.
// Assumes: tick is a single-cycle pulse synchronous to clk; OFF_MS >= 1.
module led_link_hold #(
    parameter int OFF_MS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_ok,
    input  logic chk_en,
    input  logic alt_act,
    input  logic tick,
    output logic led_n
);

    localparam int          CW     = $clog2(OFF_MS + 1);
    localparam logic [CW-1:0] HOLD_LD = CW'(OFF_MS);

    logic          want_on;
    logic [CW-1:0] hold_q;
    logic          led_q;

    // Request for the lamp before the minimum off time is applied.
    always_comb begin
        want_on = !alt_act && (!chk_en || link_ok);
    end

    // Hold counter reload and drain, and the registered lamp drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            led_q  <= 1'b1;
        end else begin
            led_q <= !(want_on && (hold_q == '0));
            if (!want_on) begin
                hold_q <= HOLD_LD;
            end else if (tick && (hold_q != '0)) begin
                hold_q <= hold_q - CW'(1);
            end
        end
    end

    assign led_n = led_q;

endmodule

// File: rtl/led_act_pulse.sv
// Module: led_act_pulse
// Turns activity events into a flash of ON_MS ticks followed by a dark gap
// of GAP_MS ticks. Events seen outside the idle phase are dropped.
// Assumes: tick and ev_any are synchronous; ON_MS >= 1 and GAP_MS >= 1.
module led_act_pulse
    import net_led_pkg::*;
#(
    parameter int ON_MS  = 50,
    parameter int GAP_MS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_any,
    input  logic tick,
    output logic led_n
);

    localparam int            MAXW  = (ON_MS > GAP_MS) ? ON_MS : GAP_MS;
    localparam int            CW    = $clog2(MAXW + 1);
    localparam logic [CW-1:0] ON_LD  = CW'(ON_MS);
    localparam logic [CW-1:0] GAP_LD = CW'(GAP_MS);

    act_phase_e    phase_q;
    logic [CW-1:0] left_q;

    // Phase sequencing and remaining-tick count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= ACT_IDLE;
            left_q  <= '0;
        end else begin
            case (phase_q)
                ACT_IDLE: begin
                    if (ev_any) begin
                        phase_q <= ACT_ON;
                        left_q  <= ON_LD;
                    end
                end
                ACT_ON: begin
                    if (tick) begin
                        if (left_q == CW'(1)) begin
                            phase_q <= ACT_GAP;
                            left_q  <= GAP_LD;
                        end else begin
                            left_q <= left_q - CW'(1);
                        end
                    end
                end
                ACT_GAP: begin
                    if (tick) begin
                        if (left_q == CW'(1)) begin
                            phase_q <= ACT_IDLE;
                            left_q  <= '0;
                        end else begin
                            left_q <= left_q - CW'(1);
                        end
                    end
                end
                default: begin
                    phase_q <= ACT_IDLE;
                    left_q  <= '0;
                end
            endcase
        end
    end

    // The lamp is lit only in the flash phase.
    assign led_n = (phase_q != ACT_ON);

endmodule

// File: rtl/led_pol_track.sv
// Module: led_pol_track
// Registers the polarity-reversed flag onto the polarity lamp. The lamp
// follows the detector flag only, so a corrected reversal stays visible.
// Assumes: pol_rev is synchronous to clk.
module led_pol_track (
    input  logic clk,
    input  logic rst_n,
    input  logic pol_rev,
    output logic led_n
);

    logic led_q;

    // One-cycle registered copy, dark in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q <= 1'b1;
        end else begin
            led_q <= !pol_rev;
        end
    end

    assign led_n = led_q;

endmodule

// File: rtl/net_led_ctrl.sv
// Module: net_led_ctrl
// Top of the network status LED controller: link, activity and polarity
// lamps, all active low, all dark in reset.
// Assumes: every input is synchronous to clk and ms_tick is a one-cycle
// pulse once per millisecond.
module net_led_ctrl #(
    parameter int LINK_OFF_MS = 100,
    parameter int ACT_ON_MS   = 50,
    parameter int ACT_GAP_MS  = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_ok,
    input  logic link_chk_en,
    input  logic alt_port_act,
    input  logic ev_tx,
    input  logic ev_rx,
    input  logic ev_col,
    input  logic pol_rev,
    input  logic ms_tick,
    output logic led_link_n,
    output logic led_act_n,
    output logic led_pol_n
);

    logic ev_any;

    // Any of the three event sources counts as activity.
    always_comb begin
        ev_any = ev_tx | ev_rx | ev_col;
    end

    led_link_hold #(.OFF_MS(LINK_OFF_MS)) u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_ok (link_ok),
        .chk_en  (link_chk_en),
        .alt_act (alt_port_act),
        .tick    (ms_tick),
        .led_n   (led_link_n)
    );

    led_act_pulse #(.ON_MS(ACT_ON_MS), .GAP_MS(ACT_GAP_MS)) u_act (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_any (ev_any),
        .tick   (ms_tick),
        .led_n  (led_act_n)
    );

    led_pol_track u_pol (
        .clk     (clk),
        .rst_n   (rst_n),
        .pol_rev (pol_rev),
        .led_n   (led_pol_n)
    );

endmodule

// File: rtl/net_led_chk.sv
// Module: net_led_chk
// Property checker for net_led_ctrl, attached by the bind below. It keeps
// its own tick counters for the dark windows so that no long $past is used.
// Assumes: same clock and reset as the block it observes.
module net_led_chk #(
    parameter int LINK_OFF_MS = 100,
    parameter int ACT_ON_MS   = 50,
    parameter int ACT_GAP_MS  = 50
) (
    input logic clk,
    input logic rst_n,
    input logic link_ok,
    input logic link_chk_en,
    input logic alt_port_act,
    input logic ev_tx,
    input logic ev_rx,
    input logic ev_col,
    input logic pol_rev,
    input logic ms_tick,
    input logic led_link_n,
    input logic led_act_n,
    input logic led_pol_n
);

    localparam int LW = $clog2(LINK_OFF_MS + 1);
    localparam int GW = $clog2(ACT_GAP_MS + 1);

    logic [LW-1:0] link_dark_ticks;
    logic [GW-1:0] act_dark_ticks;

    // Ticks seen while the link lamp has been dark, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_dark_ticks <= LW'(LINK_OFF_MS);
        end else if (!led_link_n) begin
            link_dark_ticks <= '0;
        end else if (ms_tick && (link_dark_ticks < LW'(LINK_OFF_MS))) begin
            link_dark_ticks <= link_dark_ticks + LW'(1);
        end
    end

    // Ticks seen while the activity lamp has been dark, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_dark_ticks <= GW'(ACT_GAP_MS);
        end else if (!led_act_n) begin
            act_dark_ticks <= '0;
        end else if (ms_tick && (act_dark_ticks < GW'(ACT_GAP_MS))) begin
            act_dark_ticks <= act_dark_ticks + GW'(1);
        end
    end

    AST_RESET_DARK: assert property (@(posedge clk)
        !rst_n |=> (led_link_n && led_act_n && led_pol_n)); // R1

    AST_LINK_ALT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        alt_port_act |=> led_link_n); // R4

    AST_LINK_FAIL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (link_chk_en && !link_ok) |=> led_link_n); // R4

    AST_LINK_MIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(led_link_n) |-> (link_dark_ticks >= LW'(LINK_OFF_MS))); // R5

    AST_ACT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(led_act_n) |-> $past(ev_tx || ev_rx || ev_col)); // R6

    AST_ACT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(led_act_n) |-> (act_dark_ticks >= GW'(ACT_GAP_MS))); // R8

    AST_POL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pol_rev |=> !led_pol_n); // R9

    AST_POL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !pol_rev |=> led_pol_n); // R9

endmodule

bind net_led_ctrl net_led_chk #(
    .LINK_OFF_MS (LINK_OFF_MS),
    .ACT_ON_MS   (ACT_ON_MS),
    .ACT_GAP_MS  (ACT_GAP_MS)
) u_net_led_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_ok      (link_ok),
    .link_chk_en  (link_chk_en),
    .alt_port_act (alt_port_act),
    .ev_tx        (ev_tx),
    .ev_rx        (ev_rx),
    .ev_col       (ev_col),
    .pol_rev      (pol_rev),
    .ms_tick      (ms_tick),
    .led_link_n   (led_link_n),
    .led_act_n    (led_act_n),
    .led_pol_n    (led_pol_n)
);

// File: tb/tb_net_led_ctrl.sv
`timescale 1ns/100ps
// Bench for net_led_ctrl: behavioural reference model compared every cycle,
// plus directed checks on the window boundaries.
module tb_net_led_ctrl;

    localparam int OFF_MS = 100;
    localparam int ON_MS  = 50;
    localparam int GAP_MS = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_ok = 1'b0, link_chk_en = 1'b1, alt_port_act = 1'b0;
    logic ev_tx = 1'b0, ev_rx = 1'b0, ev_col = 1'b0;
    logic pol_rev = 1'b0, ms_tick = 1'b0;
    logic led_link_n, led_act_n, led_pol_n;

    int total = 0;
    int bad = 0;
    int tick_count = 0;
    int tdiv = 0;
    bit finished = 0;

    // Reference model state
    int  m_clear;
    int  m_phase;
    int  m_cnt;
    bit  e_link = 1, e_act = 1, e_pol = 1;
    bit  model_live = 0;

    always #2.5 clk = ~clk;

    net_led_ctrl #(.LINK_OFF_MS(OFF_MS), .ACT_ON_MS(ON_MS), .ACT_GAP_MS(GAP_MS)) dut (
        .clk(clk), .rst_n(rst_n), .link_ok(link_ok), .link_chk_en(link_chk_en),
        .alt_port_act(alt_port_act), .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_col(ev_col),
        .pol_rev(pol_rev), .ms_tick(ms_tick),
        .led_link_n(led_link_n), .led_act_n(led_act_n), .led_pol_n(led_pol_n)
    );

    // Millisecond tick every third cycle, driven away from the active edge.
    always @(negedge clk) begin
        tdiv = (tdiv == 2) ? 0 : tdiv + 1;
        ms_tick = (tdiv == 0);
    end

    // Absolute tick counter used for boundary timing.
    always @(posedge clk) begin
        if (ms_tick) tick_count++;
    end

    // Behavioural reference model, updated at each edge.
    always @(posedge clk) begin
        bit want;
        if (!rst_n) begin
            m_clear = OFF_MS; m_phase = 0; m_cnt = 0;
            e_link = 1; e_act = 1; e_pol = 1;
        end else begin
            want = !alt_port_act && (!link_chk_en || link_ok);
            e_link = !(want && m_clear >= OFF_MS);
            if (!want) m_clear = 0;
            else if (ms_tick && m_clear < OFF_MS) m_clear++;
            e_pol = !pol_rev;
            if (m_phase == 0) begin
                if (ev_tx || ev_rx || ev_col) begin m_phase = 1; m_cnt = 0; end
            end else if (ms_tick) begin
                m_cnt++;
                if (m_phase == 1 && m_cnt == ON_MS) begin m_phase = 2; m_cnt = 0; end
                else if (m_phase == 2 && m_cnt == GAP_MS) begin m_phase = 0; m_cnt = 0; end
            end
            e_act = (m_phase != 1);
        end
        model_live = 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (model_live && !finished) begin
            check(led_link_n === e_link, "model link R2 R3 R4 R5", led_link_n, e_link);
            check(led_act_n  === e_act,  "model act R6 R7 R8", led_act_n, e_act);
            check(led_pol_n  === e_pol,  "model pol R9", led_pol_n, e_pol);
        end
    end

    task automatic wait_tc(input int n);
        while (tick_count < n) @(negedge clk);
    endtask

    // One-cycle dip of link_ok; returns on the negedge after the sampling edge.
    task automatic link_drop();
        @(negedge clk) link_ok = 0;
        @(negedge clk) link_ok = 1;
    endtask

    task automatic fire(input int kind);
        @(negedge clk);
        if (kind == 0) ev_tx = 1; else if (kind == 1) ev_rx = 1; else ev_col = 1;
        @(negedge clk);
        ev_tx = 0; ev_rx = 0; ev_col = 0;
    endtask

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int t0;
        int t1;
        repeat (4) @(negedge clk);
        check(led_link_n && led_act_n && led_pol_n, "R1 reset dark",
              {led_link_n, led_act_n, led_pol_n}, 7);
        link_ok = 1;
        rst_n = 1;
        @(negedge clk); @(negedge clk);
        check(led_link_n == 0, "R2 link lit", led_link_n, 0);

        // Minimum off time with a restart inside the window
        link_drop();
        check(led_link_n == 1, "R4 link fail dark", led_link_n, 1);
        t0 = tick_count;
        wait_tc(t0 + 60);
        check(led_link_n == 1, "R5 still dark mid hold", led_link_n, 1);
        link_drop();
        t0 = tick_count;
        wait_tc(t0 + 99);
        check(led_link_n == 1, "R5 restart hold 99", led_link_n, 1);
        wait_tc(t0 + 100);
        check(led_link_n == 1, "R5 dark at last tick", led_link_n, 1);
        @(negedge clk);
        check(led_link_n == 0, "R5 lit after hold", led_link_n, 0);

        // Alternate port forces dark
        @(negedge clk) alt_port_act = 1;
        @(negedge clk);
        check(led_link_n == 1, "R4 alt port dark", led_link_n, 1);
        alt_port_act = 0;
        @(negedge clk);
        t0 = tick_count;
        wait_tc(t0 + 101);
        @(negedge clk);
        check(led_link_n == 0, "R5 lit after alt", led_link_n, 0);

        // Check disabled: link_ok low has no effect
        @(negedge clk) begin link_chk_en = 0; link_ok = 0; end
        repeat (3) @(negedge clk);
        check(led_link_n == 0, "R3 check off keeps lit", led_link_n, 0);
        link_chk_en = 1;
        @(negedge clk);
        check(led_link_n == 1, "R4 check on link bad", led_link_n, 1);

        // Polarity lamp independent of link state
        pol_rev = 1;
        @(negedge clk);
        check(led_pol_n == 0, "R9 pol lit link down", led_pol_n, 0);
        pol_rev = 0;
        @(negedge clk);
        check(led_pol_n == 1, "R9 pol dark", led_pol_n, 1);
        link_ok = 1;

        // Activity flash, absorbed event, gap, new flash
        fire(0);
        t0 = tick_count;
        check(led_act_n == 0, "R6 act lit on tx", led_act_n, 0);
        wait_tc(t0 + 20);
        fire(1);
        wait_tc(t0 + 49);
        check(led_act_n == 0, "R6 act lit tick 49", led_act_n, 0);
        wait_tc(t0 + 50);
        check(led_act_n == 1, "R7 flash not extended", led_act_n, 1);
        t1 = t0 + 50;
        wait_tc(t1 + 10);
        fire(2);
        check(led_act_n == 1, "R8 event in gap ignored", led_act_n, 1);
        wait_tc(t1 + 49);
        fire(2);
        check(led_act_n == 1, "R8 gap tick 49 ignored", led_act_n, 1);
        wait_tc(t1 + 50);
        fire(2);
        check(led_act_n == 0, "R8 new flash after gap", led_act_n, 0);

        // Random traffic, compared every cycle against the model
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 199) == 0) link_ok = ~link_ok;
            if ($urandom_range(0, 499) == 0) link_chk_en = ~link_chk_en;
            if ($urandom_range(0, 699) == 0) alt_port_act = ~alt_port_act;
            if ($urandom_range(0, 299) == 0) pol_rev = ~pol_rev;
            ev_tx  = ($urandom_range(0, 39) == 0);
            ev_rx  = ($urandom_range(0, 39) == 0);
            ev_col = ($urandom_range(0, 79) == 0);
        end
        @(negedge clk);
        ev_tx = 0; ev_rx = 0; ev_col = 0;
        repeat (2) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule